// File: doc/BRIEF.md
# Swizzled Operand Address Sequencer

This block produces the physical shared-memory byte addresses needed to fetch one matrix-multiply operand tile, one 16-byte unit per beat. The tile is held in memory as a grid of swizzle atoms. An atom for a swizzle width of `s` bytes has 8 rows of `s` bytes and occupies one contiguous block of `8*s` bytes. Inside an atom, 16-byte units are permuted by an XOR pattern. Bytes inside a unit are never reordered, and no unit leaves its atom. Atoms are placed in memory by two strides: `sbo` is the distance between neighbouring atoms along the strided dimension, and `lbo` is the distance between neighbouring atoms along the leading dimension.

A one-cycle `start` in the idle state captures the configuration and launches a walk. The walk visits units in this order:
- the unit within a row first,
- then the row within the atom,
- then atoms along the strided dimension,
- then atoms along the leading dimension.

Each address is offered on a valid/ready handshake. A `done` pulse follows the last accepted beat. The controller has three states:
- `ST_IDLE`: waiting for work.
- `ST_EMIT`: offering beats.
- `ST_DONE`: one cycle of `done`.

The transitions are:
- IDLE→EMIT on `start`.
- EMIT→EMIT on a stall, or on an accepted beat that is not the last.
- EMIT→DONE on acceptance of the last beat.
- DONE→IDLE unconditionally.

Top module: `swz_addr_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, `valid` and `done` are low.
- R2: A `start` in idle makes `valid` high in the very next cycle. `valid` then stays high until the last beat is accepted.
- R3: `swz_mode` selects the swizzle width: 0 is none, 1 is 32 B, 2 is 64 B and 3 is 128 B. Call this code B; rows are `16<<B` bytes wide.
  - The unit at row `r`, column `u` has within-atom offset `o = r*(16<<B) + u*16`.
  - The emitted offset is `o` with bits [6+B:7] XORed into bits [3+B:4].
- R4: With `swz_mode`=0, each atom has one 16-byte unit per row. The eight units are emitted at offsets 0,16,…,112, in that linear order.
- R5: `str_atoms_m1` and `lead_atoms_m1` hold the atom counts minus one.
  - Units advance first, then rows (8 per atom), then strided atoms, then leading atoms.
  - Each address is `base_addr + sa*sbo + la*lbo + emitted offset`, modulo 2^ADDR_W. Here `sa` and `la` are the strided and leading atom indices.
- R6: With `k_major`=1 and a nonzero `swz_mode`, `lbo` and `lead_atoms_m1` are ignored. The walk covers exactly one leading atom.
- R7: With `swz_mode`=3 and `k_major`=1, the first two beats of row 1 (beats 8 and 9) land at base+144 and base+128. This is the swapped pair of the 128 B pattern.
- R8: While `valid` is high and `ready` is low, `valid` stays high and `addr` holds its value into the next cycle.
- R9: `done` is high for exactly one cycle: the cycle after the final beat is accepted. `valid` is low in that cycle.
- R10: A `start` during a walk or in the done cycle is ignored. The address sequence continues unchanged, and no new walk begins after `done`.
- R11: During a walk, `unit_elems` shows the element count of one 16-byte unit, which is 128 divided by the element width. For `elem_width_sel` 0, 1, 2 and 3, the element widths are 8, 16, 32 and 4 bits, giving 16, 8, 4 and 32.
- R12: When `k_major`=0, or `swz_mode`=0, both `lbo` and `lead_atoms_m1` take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled in idle only |
| base_addr | input | ADDR_W | Byte address of the first atom |
| swz_mode | input | 2 | Swizzle width code (0 none, 1 32 B, 2 64 B, 3 128 B) |
| k_major | input | 1 | 1 = K-major operand, 0 = MN-major |
| sbo | input | OFF_W | Byte distance between strided-neighbour atoms |
| lbo | input | OFF_W | Byte distance between leading-neighbour atoms |
| elem_width_sel | input | 2 | Element width code (8, 16, 32, 4 bits) |
| str_atoms_m1 | input | CNT_W | Strided atom count minus one |
| lead_atoms_m1 | input | CNT_W | Leading atom count minus one |
| ready | input | 1 | Consumer accepts the current beat |
| valid | output | 1 | A beat is offered |
| addr | output | ADDR_W | Physical byte address of the offered unit |
| unit_elems | output | 6 | Elements per 16-byte unit for the captured width |
| done | output | 1 | One-cycle pulse after the last accepted beat |

## Verification
The first beat is due one cycle after the `start` edge, because only the state register lies in between. Each later address is due one cycle after the edge that accepted the previous beat. `done` is due one cycle after the final acceptance edge.

The bench drives `start` and `ready` on falling edges and samples all outputs on the next falling edge. It keeps a beat index that advances only when `valid` and `ready` were both high at that sample. It expects `done` exactly at the sample following the final acceptance. The sweep covers every swizzle mode, both majorness settings, and one or two atoms on each axis, with an irregular ready pattern so that stalls land at many positions.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [1:0] {
        SWZ_NONE = 2'd0,
        SWZ_32B  = 2'd1,
        SWZ_64B  = 2'd2,
        SWZ_128B = 2'd3
    } swz_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    localparam int UNIT_SHIFT   = 4;   // 16-byte unit
    localparam int ROWS         = 8;
    localparam int ROW_W        = $clog2(ROWS);
    localparam int UNIT_IDX_W   = 3;   // up to 8 units per row
    localparam int ATOM_OFF_W   = ROW_W + UNIT_IDX_W + UNIT_SHIFT; // 1 KiB atom max
    localparam int XOR_SRC_LSB  = UNIT_SHIFT + UNIT_IDX_W;         // bit 7

    function automatic logic [5:0] elems_per_unit(input logic [1:0] sel);
        logic [5:0] n;
        unique case (sel)
            2'd0: n = 6'd16;
            2'd1: n = 6'd8;
            2'd2: n = 6'd4;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/swz_unit_ctr.sv
module swz_unit_ctr
    import swz_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  step,
    input  swz_mode_e             mode,
    output logic                  atom_wrap,
    output logic [ATOM_OFF_W-1:0] atom_off
);

    logic [UNIT_IDX_W-1:0] unit_q;
    logic [ROW_W-1:0]      row_q;
    logic [UNIT_IDX_W-1:0] unit_max;
    logic                  unit_last;
    logic                  row_last;

    always_comb begin
        unique case (mode)
            SWZ_NONE: unit_max = 3'd0;
            SWZ_32B:  unit_max = 3'd1;
            SWZ_64B:  unit_max = 3'd3;
            default:  unit_max = 3'd7;
        endcase
    end

    assign unit_last = (unit_q == unit_max);
    assign row_last  = (row_q == ROW_W'(ROWS - 1));
    assign atom_wrap = unit_last && row_last;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            unit_q <= '0;
            row_q  <= '0;
        end else if (step) begin
            if (unit_last) begin
                unit_q <= '0;
                row_q  <= row_last ? '0 : row_q + 1'b1;
            end else begin
                unit_q <= unit_q + 1'b1;
            end
        end
    end

    logic [ATOM_OFF_W-1:0] row_part;
    logic [ATOM_OFF_W-1:0] unit_part;

    always_comb begin
        row_part  = ATOM_OFF_W'(row_q) << (UNIT_SHIFT + int'(mode));
        unit_part = ATOM_OFF_W'(unit_q) << UNIT_SHIFT;
        atom_off  = row_part | unit_part;
    end

endmodule

// File: rtl/swz_atom_ctr.sv
module swz_atom_ctr #(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 20,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [OFF_W-1:0]  str_stride,
    input  logic [OFF_W-1:0]  lead_stride,
    input  logic [CNT_W-1:0]  str_m1,
    input  logic [CNT_W-1:0]  lead_m1,
    output logic [ADDR_W-1:0] atom_addr,
    output logic              last_atom
);

    logic [ADDR_W-1:0] lead_ptr_q;
    logic [ADDR_W-1:0] str_ptr_q;
    logic [CNT_W-1:0]  sa_q;
    logic [CNT_W-1:0]  la_q;
    logic [ADDR_W-1:0] next_lead;
    logic              str_end;

    assign str_end   = (sa_q == str_m1);
    assign last_atom = str_end && (la_q == lead_m1);
    assign next_lead = lead_ptr_q + ADDR_W'(lead_stride);
    assign atom_addr = str_ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_ptr_q <= '0;
            str_ptr_q  <= '0;
            sa_q       <= '0;
            la_q       <= '0;
        end else if (clear) begin
            lead_ptr_q <= base_in;
            str_ptr_q  <= base_in;
            sa_q       <= '0;
            la_q       <= '0;
        end else if (step) begin
            if (str_end) begin
                sa_q       <= '0;
                la_q       <= la_q + 1'b1;
                lead_ptr_q <= next_lead;
                str_ptr_q  <= next_lead;
            end else begin
                sa_q      <= sa_q + 1'b1;
                str_ptr_q <= str_ptr_q + ADDR_W'(str_stride);
            end
        end
    end

endmodule

// File: rtl/swz_remap.sv
module swz_remap
    import swz_pkg::*;
(
    input  swz_mode_e             mode,
    input  logic [ATOM_OFF_W-1:0] off_in,
    output logic [ATOM_OFF_W-1:0] off_out
);

    logic [UNIT_IDX_W-1:0] lane_en;

    always_comb begin
        unique case (mode)
            SWZ_NONE: lane_en = 3'b000;
            SWZ_32B:  lane_en = 3'b001;
            SWZ_64B:  lane_en = 3'b011;
            default:  lane_en = 3'b111;
        endcase
    end

    assign off_out[UNIT_SHIFT-1:0] = off_in[UNIT_SHIFT-1:0];

    for (genvar i = 0; i < UNIT_IDX_W; i++) begin : g_xor
        assign off_out[UNIT_SHIFT + i] =
            off_in[UNIT_SHIFT + i] ^ (lane_en[i] & off_in[XOR_SRC_LSB + i]);
    end

    assign off_out[ATOM_OFF_W-1:XOR_SRC_LSB] = off_in[ATOM_OFF_W-1:XOR_SRC_LSB];

endmodule

// File: rtl/swz_addr_seq.sv
module swz_addr_seq
    import swz_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 20,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [1:0]        swz_mode,
    input  logic              k_major,
    input  logic [OFF_W-1:0]  sbo,
    input  logic [OFF_W-1:0]  lbo,
    input  logic [1:0]        elem_width_sel,
    input  logic [CNT_W-1:0]  str_atoms_m1,
    input  logic [CNT_W-1:0]  lead_atoms_m1,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [5:0]        unit_elems,
    output logic              done
);

    seq_state_e state_q, state_d;

    swz_mode_e        mode_q;
    logic [OFF_W-1:0] sbo_q;
    logic [OFF_W-1:0] lbo_q;
    logic [CNT_W-1:0] str_m1_q;
    logic [CNT_W-1:0] lead_m1_q;
    logic [1:0]       ew_q;

    logic launch;
    logic fire;
    logic atom_wrap;
    logic last_atom;
    logic last_beat;
    logic lead_unused;
    logic [ATOM_OFF_W-1:0] raw_off;
    logic [ATOM_OFF_W-1:0] phys_off;
    logic [ADDR_W-1:0]     atom_addr;

    assign launch      = start && (state_q == ST_IDLE);
    assign fire        = valid && ready;
    assign last_beat   = atom_wrap && last_atom;
    assign lead_unused = k_major && (swz_mode_e'(swz_mode) != SWZ_NONE);

    // configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= SWZ_NONE;
            sbo_q     <= '0;
            lbo_q     <= '0;
            str_m1_q  <= '0;
            lead_m1_q <= '0;
            ew_q      <= '0;
        end else if (launch) begin
            mode_q    <= swz_mode_e'(swz_mode);
            sbo_q     <= sbo;
            lbo_q     <= lead_unused ? '0 : lbo;
            str_m1_q  <= str_atoms_m1;
            lead_m1_q <= lead_unused ? '0 : lead_atoms_m1;
            ew_q      <= elem_width_sel;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EMIT;
            ST_EMIT: if (fire && last_beat) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EMIT: valid = 1'b1;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
    end

    swz_unit_ctr u_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .step      (fire),
        .mode      (mode_q),
        .atom_wrap (atom_wrap),
        .atom_off  (raw_off)
    );

    swz_atom_ctr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .CNT_W  (CNT_W)
    ) u_atom (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (launch),
        .step        (fire && atom_wrap),
        .base_in     (base_addr),
        .str_stride  (sbo_q),
        .lead_stride (lbo_q),
        .str_m1      (str_m1_q),
        .lead_m1     (lead_m1_q),
        .atom_addr   (atom_addr),
        .last_atom   (last_atom)
    );

    swz_remap u_remap (
        .mode    (mode_q),
        .off_in  (raw_off),
        .off_out (phys_off)
    );

    assign addr       = atom_addr + ADDR_W'(phys_off);
    assign unit_elems = elems_per_unit(ew_q);

endmodule

// File: rtl/swz_addr_seq_chk.sv
module swz_addr_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              valid,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);

    assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid && ready));

    assert_launch_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(start));

endmodule

bind swz_addr_seq swz_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ready (ready),
    .valid (valid),
    .addr  (addr),
    .done  (done)
);

// File: tb/swz_addr_seq_test.sv
`timescale 1ns/1ps
module swz_addr_seq_test;

    localparam int ADDR_W = 24;
    localparam int OFF_W  = 20;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [ADDR_W-1:0] base_addr;
    logic [1:0]        swz_mode;
    logic              k_major;
    logic [OFF_W-1:0]  sbo;
    logic [OFF_W-1:0]  lbo;
    logic [1:0]        elem_width_sel;
    logic [CNT_W-1:0]  str_atoms_m1;
    logic [CNT_W-1:0]  lead_atoms_m1;
    logic              ready;
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [5:0]        unit_elems;
    logic              done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    swz_addr_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .swz_mode(swz_mode), .k_major(k_major), .sbo(sbo), .lbo(lbo),
        .elem_width_sel(elem_width_sel), .str_atoms_m1(str_atoms_m1),
        .lead_atoms_m1(lead_atoms_m1), .ready(ready), .valid(valid),
        .addr(addr), .unit_elems(unit_elems), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic longint exp_addr(int idx, int mode, int sm1,
                                        longint base, longint sb, longint lb);
        int upr = 1 << mode;
        int u   = idx % upr;
        int r   = (idx / upr) % 8;
        int a   = idx / (upr * 8);
        int sa  = a % (sm1 + 1);
        int la  = a / (sm1 + 1);
        int off = r * (16 << mode) + u * 16;
        int sw  = off ^ (((off >> 7) & (upr - 1)) << 4);
        return (base + sa * sb + la * lb + sw) & 64'hFF_FFFF;
    endfunction

    function automatic int exp_elems(int sel);
        case (sel)
            0: return 16;
            1: return 8;
            2: return 4;
            default: return 32;
        endcase
    endfunction

    task automatic run_cfg(input int mode, input bit km, input int sm1, input int lm1,
                           input int ew, input bit inject);
        longint base = 64'h012000 + mode * 64'h30;
        longint sb   = 64'h1000;
        longint lb   = 64'h4000;
        int lm_eff   = (km && mode != 0) ? 0 : lm1;
        int total    = (1 << mode) * 8 * (sm1 + 1) * (lm_eff + 1);
        int idx      = 0;
        int cyc      = 0;
        bit exp_done = 0;
        bit seen     = 0;
        bit stalled  = 0;
        bit injected = 0;
        logic [ADDR_W-1:0] prev = '0;
        string tag;

        @(negedge clk);
        base_addr      = base[ADDR_W-1:0];
        swz_mode       = 2'(mode);
        k_major        = km;
        sbo            = sb[OFF_W-1:0];
        lbo            = lb[OFF_W-1:0];
        elem_width_sel = 2'(ew);
        str_atoms_m1   = CNT_W'(sm1);
        lead_atoms_m1  = CNT_W'(lm1);
        ready          = 1'b0;
        start          = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: first beat offered one cycle after the start edge
        check(valid == 1'b1, "R2", valid, 1);

        while (!seen && cyc < 5000) begin
            start = 1'b0;
            ready = ((cyc * 5 + mode + km) % 4) != 0;
            if (inject && !injected && idx == 2) begin
                start    = 1'b1;   // R10: must be ignored
                injected = 1;
            end
            check(done == exp_done, "R9", done, exp_done);
            if (done) begin
                seen = 1;
                check(valid == 1'b0, "R9", valid, 0);
            end else if (idx < total) begin
                check(valid == 1'b1, "R2", valid, 1);
            end
            if (valid && idx < total) begin
                longint e = exp_addr(idx, mode, sm1, base, sb, lb);
                int     a = idx / ((1 << mode) * 8);
                if (a / (sm1 + 1) > 0)       tag = "R12";
                else if (a > 0)              tag = "R5";
                else if (mode == 0)          tag = "R4";
                else if (km)                 tag = "R6";
                else                         tag = "R3";
                if (injected)                tag = {tag, " R10"};
                check(addr == e[ADDR_W-1:0], tag, addr, e);
                check(unit_elems == 6'(exp_elems(ew)), "R11", unit_elems, exp_elems(ew));
                if (stalled) check(addr == prev, "R8", addr, prev);
                if (mode == 3 && km && (idx == 8 || idx == 9)) begin
                    longint r7 = base + ((idx == 8) ? 144 : 128);
                    check(addr == r7[ADDR_W-1:0], "R7", addr, r7);
                end
            end
            stalled  = valid && !ready;
            prev     = addr;
            exp_done = valid && ready && (idx == total - 1);
            if (valid && ready) idx++;
            cyc++;
            @(negedge clk);
        end
        check(seen, "R9", seen, 1);
        start = 1'b0;
        ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check(valid == 1'b0 && done == 1'b0, inject ? "R10" : "R9", valid, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; ready = 1'b0;
        base_addr = '0; swz_mode = '0; k_major = 1'b0; sbo = '0; lbo = '0;
        elem_width_sel = '0; str_atoms_m1 = '0; lead_atoms_m1 = '0;
        repeat (3) @(negedge clk);
        check(valid == 1'b0 && done == 1'b0, "R1", {valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0 && done == 1'b0, "R1", {valid, done}, 0);

        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 2; k++)
                for (int s = 0; s < 2; s++)
                    for (int l = 0; l < 2; l++)
                        run_cfg(m, k[0], s, l, (m + k + s) % 4, (s == 1) && (l == 0));

        summary();
    end

endmodule